// File: doc/BRIEF.md
# GPIO Event Detector with Grouped Interrupts

This block watches every pin of a 54-pin general-purpose port and records selected events in a sticky per-pin status bit. Each pin can be armed for any mix of six event kinds. Four of them work on the already-synchronized pin level: a rising edge, a falling edge, a high level and a low level. The other two catch rising and falling edges on the raw pin, which has no synchronizer in front of it. Software arms the detectors and clears latched events over a simple 32-bit register bus. A status bit is cleared by writing a 1 to it.

The status bits are merged into three interrupt lines, each covering a fixed range of pins. An interrupt controller elsewhere consumes these lines. A latched bit stays set until software clears it, even if its detector has since been disarmed. A level detector whose pin still sits at the armed level sets its bit again on the same clock as the clear, so that level cannot be cleared away.

Register map (byte offsets on `bus_addr`, two banks per register at +0 and +4, bank 0 holds pins 0–31 and bank 1 holds pins 32–53 in bits 0–21): status 0x40, rising 0x4C, falling 0x58, high level 0x64, low level 0x70, raw rising 0x7C, raw falling 0x88.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset all six enable registers and the status register read 0, and all three interrupt lines are 0.
- R2: With the rising enable set for a pin, a 0-to-1 change of its synchronized level seen at a clock edge sets its status bit at that edge.
- R3: With the falling enable set for a pin, a 1-to-0 change of its synchronized level sets its status bit. A rising change does not set it.
- R4: With both the rising and the falling enables set, each edge direction sets the status bit.
- R5: With the high-level enable set, the status bit sets while the synchronized level is 1. A clear written while the pin stays high leaves the bit reading 1.
- R6: With the low-level enable set, the status bit sets while the synchronized level is 0. Once the pin is high, a clear takes effect.
- R7: The raw-rising enable flags a 0-to-1 change of the raw pin even when the synchronized level does not change. A raw-only change does not trigger the synchronized edge detectors.
- R8: The raw-falling enable flags a 1-to-0 change of the raw pin and ignores a 0-to-1 change.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R10: Clearing a pin's enable leaves an already-latched status bit set until it is cleared by a write.
- R11: When a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R12: Interrupt line 0 is high while any status bit of pins 0–27 is set, line 1 covers pins 28–45 and line 2 covers pins 46–53 (irq_line bit index = line number).
- R13: Enable registers read back what was written. Bits of bank 1 above pin 53 (bits 22–31) read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_raw | input | 54 | Unsynchronized pin levels for raw edge detection |
| pin_sync | input | 54 | Synchronized pin levels |
| bus_we | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_line | output | 3 | Grouped interrupt lines |

## Verification
The two functions that can land on the same cycle are a software clear of a status bit and a fresh detection on that same bit. The bench provokes this by driving a clear strobe and a new rising edge of the pin in the same cycle. It judges the result by reading the status afterwards and expects the bit still set. The high-level case is a second collision of the same kind: a clear written while the pin is held at its armed level must leave the bit reading 1.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [2:0] {
    KIND_STATUS = 3'd0,
    KIND_RISE   = 3'd1,
    KIND_FALL   = 3'd2,
    KIND_HIGH   = 3'd3,
    KIND_LOW    = 3'd4,
    KIND_ARISE  = 3'd5,
    KIND_AFALL  = 3'd6
  } reg_kind_e;

  localparam int unsigned NUM_KINDS   = 7;
  localparam int unsigned NUM_EN      = NUM_KINDS - 1;
  localparam int unsigned ADDR_BASE   = 'h40;
  localparam int unsigned KIND_STRIDE = 12;
  localparam int unsigned BANK_STRIDE = 4;

endpackage

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [NUM_PINS-1:0] status_q,
  output logic [NUM_PINS-1:0] en_rise,
  output logic [NUM_PINS-1:0] en_fall,
  output logic [NUM_PINS-1:0] en_high,
  output logic [NUM_PINS-1:0] en_low,
  output logic [NUM_PINS-1:0] en_arise,
  output logic [NUM_PINS-1:0] en_afall,
  output logic [NUM_PINS-1:0] clr_mask,
  output logic [DATA_W-1:0]   bus_rdata
);

  localparam int unsigned BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;

  logic [NUM_KINDS-1:0][BANKS-1:0] hit;
  logic [NUM_PINS-1:0] en_q [NUM_EN];
  logic [NUM_PINS-1:0] en_d [NUM_EN];
  logic [NUM_EN-1:0]   en_wr;

  // address decode: one compare per register word
  always_comb begin
    for (int k = 0; k < NUM_KINDS; k++) begin
      for (int b = 0; b < BANKS; b++) begin
        hit[k][b] = (bus_addr == ADDR_W'(ADDR_BASE + k * KIND_STRIDE + b * BANK_STRIDE));
      end
    end
  end

  // next state of the enable words and the clear mask
  always_comb begin
    for (int e = 0; e < NUM_EN; e++) begin
      en_wr[e] = bus_we && (|hit[e+1]);
      for (int i = 0; i < NUM_PINS; i++) begin
        en_d[e][i] = hit[e+1][i / DATA_W] ? bus_wdata[i % DATA_W] : en_q[e][i];
      end
    end
    for (int i = 0; i < NUM_PINS; i++) begin
      clr_mask[i] = bus_we && hit[KIND_STATUS][i / DATA_W] && bus_wdata[i % DATA_W];
    end
  end

  generate
    for (genvar e = 0; e < NUM_EN; e++) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[e] <= '0;
        end else if (en_wr[e]) begin
          en_q[e] <= en_d[e];
        end
      end
    end
  endgenerate

  assign en_rise  = en_q[0];
  assign en_fall  = en_q[1];
  assign en_high  = en_q[2];
  assign en_low   = en_q[3];
  assign en_arise = en_q[4];
  assign en_afall = en_q[5];

  // read mux, bits above the last pin stay 0
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      bus_rdata[i % DATA_W] = bus_rdata[i % DATA_W]
                            | (hit[KIND_STATUS][i / DATA_W] & status_q[i]);
      for (int e = 0; e < NUM_EN; e++) begin
        bus_rdata[i % DATA_W] = bus_rdata[i % DATA_W]
                              | (hit[e+1][i / DATA_W] & en_q[e][i]);
      end
    end
  end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] en_rise,
  input  logic [NUM_PINS-1:0] en_fall,
  input  logic [NUM_PINS-1:0] en_high,
  input  logic [NUM_PINS-1:0] en_low,
  input  logic [NUM_PINS-1:0] en_arise,
  input  logic [NUM_PINS-1:0] en_afall,
  output logic [NUM_PINS-1:0] evt
);

  logic [NUM_PINS-1:0] sync_q, sync_d;
  logic [NUM_PINS-1:0] raw_q, raw_d;

  always_comb begin
    sync_d = pin_sync;
    raw_d  = pin_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      raw_q  <= '0;
    end else begin
      sync_q <= sync_d;
      raw_q  <= raw_d;
    end
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic s_up, s_dn, r_up, r_dn;
      assign s_up   = pin_sync[i] & ~sync_q[i];
      assign s_dn   = ~pin_sync[i] & sync_q[i];
      assign r_up   = pin_raw[i] & ~raw_q[i];
      assign r_dn   = ~pin_raw[i] & raw_q[i];
      assign evt[i] = (en_rise[i]  & s_up)
                    | (en_fall[i]  & s_dn)
                    | (en_high[i]  & pin_sync[i])
                    | (en_low[i]   & ~pin_sync[i])
                    | (en_arise[i] & r_up)
                    | (en_afall[i] & r_dn);
    end
  endgenerate

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned NUM_IRQ  = 3,
  parameter int unsigned IRQ_FIRST [NUM_IRQ] = '{0, 28, 46}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] status_q,
  output logic [NUM_IRQ-1:0]  irq
);

  logic [NUM_PINS-1:0] status_d;

  function automatic int unsigned group_of(input int unsigned pin);
    int unsigned g = 0;
    for (int unsigned k = 1; k < NUM_IRQ; k++) begin
      if (pin >= IRQ_FIRST[k]) g = k;
    end
    return g;
  endfunction

  // a new event wins over a clear of the same bit
  always_comb begin
    status_d = (status_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

  always_comb begin
    irq = '0;
    for (int unsigned i = 0; i < NUM_PINS; i++) begin
      irq[group_of(i)] = irq[group_of(i)] | status_q[i];
    end
  end

  // R11: every detected event is visible in the status one cycle later
  a_r11_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(evt)) == '0));

  // R9: a cleared bit with no event in that cycle reads 0 afterwards
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_mask & ~evt)) == '0));

  // R10: a set bit that was not cleared stays set
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q & ~clr_mask) & ~status_q) == '0));

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_IRQ  = 3,
  parameter int unsigned IRQ_FIRST [NUM_IRQ] = '{0, 28, 46}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_IRQ-1:0]  irq_line
);

  logic rst_meta, rst_int_n;
  logic [NUM_PINS-1:0] en_rise, en_fall, en_high, en_low, en_arise, en_afall;
  logic [NUM_PINS-1:0] clr_mask, evt, status_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  gpio_evt_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .en_high   (en_high),
    .en_low    (en_low),
    .en_arise  (en_arise),
    .en_afall  (en_afall),
    .clr_mask  (clr_mask),
    .bus_rdata (bus_rdata)
  );

  gpio_evt_detect #(
    .NUM_PINS (NUM_PINS)
  ) u_detect (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin_raw  (pin_raw),
    .pin_sync (pin_sync),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .en_high  (en_high),
    .en_low   (en_low),
    .en_arise (en_arise),
    .en_afall (en_afall),
    .evt      (evt)
  );

  gpio_evt_status #(
    .NUM_PINS  (NUM_PINS),
    .NUM_IRQ   (NUM_IRQ),
    .IRQ_FIRST (IRQ_FIRST)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt      (evt),
    .clr_mask (clr_mask),
    .status_q (status_q),
    .irq      (irq_line)
  );

  // R12: no interrupt while nothing is latched
  a_r12_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status_q == '0) |-> (irq_line == '0));

  // R1: the first cycle out of reset shows no interrupt
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (irq_line == '0));

endmodule

// File: tb/gpio_evt_unit_bench.sv
module gpio_evt_unit_bench;

  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_raw, pin_sync;
  logic          bus_we;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [2:0]    irq_line;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_evt_unit u_gpio_evt_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (pin_raw),
    .pin_sync  (pin_sync),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_line  (irq_line)
  );

  // kind: 0 status, 1 rise, 2 fall, 3 high, 4 low, 5 raw rise, 6 raw fall
  function automatic logic [7:0] addr_of(input int kind, input int bank);
    return 8'(8'h40 + kind * 12 + bank * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int kind, input int bank, input logic [31:0] data);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = addr_of(kind, bank);
    bus_wdata = data;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int kind, input int bank, output logic [31:0] data);
    bus_addr = addr_of(kind, bank);
    #1;
    data = bus_rdata;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin_sync[idx] = v;
    pin_raw[idx]  = v;
    @(negedge clk);
  endtask

  task automatic set_raw(input int idx, input logic v);
    @(negedge clk);
    pin_raw[idx] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int k = 0; k < 7; k++) begin
      for (int b = 0; b < 2; b++) begin
        rd(k, b, d);
        chk("R1 register zero after reset", d, 32'h0);
      end
    end
    chk("R1 irq after reset", {29'h0, irq_line}, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(1, 0, 32'h1 << 4);
    set_pin(4, 1'b1);
    rd(0, 0, d);
    chk("R2 rising edge latched", d, 32'h10);
    chk("R2 irq line 0", {29'h0, irq_line}, 32'h1);
    wr(0, 0, 32'h10);
    set_pin(4, 1'b0);
    rd(0, 0, d);
    chk("R3 falling ignored by rise enable", d, 32'h0);
    wr(1, 0, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(2, 1, 32'h2);
    set_pin(33, 1'b1);
    rd(0, 1, d);
    chk("R3 rising ignored by fall enable", d, 32'h0);
    set_pin(33, 1'b0);
    rd(0, 1, d);
    chk("R3 falling edge latched", d, 32'h2);
    chk("R3 irq line 1", {29'h0, irq_line}, 32'h2);
    wr(0, 1, 32'h2);
    wr(2, 1, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(1, 0, 32'h400);
    wr(2, 0, 32'h400);
    set_pin(10, 1'b1);
    rd(0, 0, d);
    chk("R4 both enables rising", d, 32'h400);
    wr(0, 0, 32'h400);
    set_pin(10, 1'b0);
    rd(0, 0, d);
    chk("R4 both enables falling", d, 32'h400);
    wr(0, 0, 32'h400);
    wr(1, 0, 32'h0);
    wr(2, 0, 32'h0);
  endtask

  task automatic t_high();
    logic [31:0] d;
    set_pin(50, 1'b1);
    wr(3, 1, 32'h1 << 18);
    tick(1);
    rd(0, 1, d);
    chk("R5 high level latched", d, 32'h40000);
    chk("R5 irq line 2", {29'h0, irq_line}, 32'h4);
    wr(0, 1, 32'h40000);
    tick(1);
    rd(0, 1, d);
    chk("R5 clear while high keeps bit", d, 32'h40000);
    set_pin(50, 1'b0);
    wr(0, 1, 32'h40000);
    rd(0, 1, d);
    chk("R5 clear after pin low", d, 32'h0);
    wr(3, 1, 32'h0);
  endtask

  task automatic t_low();
    logic [31:0] d;
    wr(4, 0, 32'h8);
    tick(1);
    rd(0, 0, d);
    chk("R6 low level latched", d, 32'h8);
    set_pin(3, 1'b1);
    wr(0, 0, 32'h8);
    rd(0, 0, d);
    chk("R6 clear after pin high", d, 32'h0);
    wr(4, 0, 32'h0);
    set_pin(3, 1'b0);
  endtask

  task automatic t_async();
    logic [31:0] d;
    wr(5, 0, 32'h1 << 20);
    wr(1, 0, 32'h1 << 21);
    wr(6, 1, 32'h100);
    set_raw(20, 1'b1);
    set_raw(21, 1'b1);
    rd(0, 0, d);
    chk("R7 raw rising latched, sync rise not fired", d, 32'h100000);
    set_raw(40, 1'b1);
    rd(0, 1, d);
    chk("R8 raw rising ignored by raw fall enable", d, 32'h0);
    set_raw(40, 1'b0);
    rd(0, 1, d);
    chk("R8 raw falling latched", d, 32'h100);
    chk("R12 irq lines 0 and 1", {29'h0, irq_line}, 32'h3);
    set_raw(20, 1'b0);
    set_raw(21, 1'b0);
    wr(0, 0, 32'h100000);
    wr(0, 1, 32'h100);
    wr(5, 0, 32'h0);
    wr(1, 0, 32'h0);
    wr(6, 1, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(1, 0, 32'h410);
    set_pin(4, 1'b1);
    set_pin(10, 1'b1);
    wr(0, 0, 32'h0);
    rd(0, 0, d);
    chk("R9 write of zero keeps bits", d, 32'h410);
    wr(0, 0, 32'h10);
    rd(0, 0, d);
    chk("R9 write of one clears only that bit", d, 32'h400);
    wr(1, 0, 32'h0);
    set_pin(4, 1'b0);
    set_pin(10, 1'b0);
    wr(0, 0, 32'h400);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(1, 0, 32'h80);
    set_pin(7, 1'b1);
    wr(1, 0, 32'h0);
    tick(2);
    rd(0, 0, d);
    chk("R10 status kept after disable", d, 32'h80);
    wr(0, 0, 32'h80);
    rd(0, 0, d);
    chk("R10 status cleared by write", d, 32'h0);
    set_pin(7, 1'b0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(1, 0, 32'h1000);
    set_pin(12, 1'b1);
    set_pin(12, 1'b0);
    @(negedge clk);
    bus_we       = 1'b1;
    bus_addr     = addr_of(0, 0);
    bus_wdata    = 32'h1000;
    pin_sync[12] = 1'b1;
    pin_raw[12]  = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(0, 0, d);
    chk("R11 event wins over clear", d, 32'h1000);
    wr(0, 0, 32'h1000);
    rd(0, 0, d);
    chk("R11 plain clear afterwards", d, 32'h0);
    wr(1, 0, 32'h0);
    set_pin(12, 1'b0);
  endtask

  task automatic t_groups();
    int pins[5] = '{27, 28, 45, 46, 53};
    logic [2:0] exp[5] = '{3'b001, 3'b010, 3'b010, 3'b100, 3'b100};
    for (int j = 0; j < 5; j++) begin
      wr(1, pins[j] / 32, 32'h1 << (pins[j] % 32));
      set_pin(pins[j], 1'b1);
      chk($sformatf("R12 irq for pin %0d", pins[j]), {29'h0, irq_line}, {29'h0, exp[j]});
      wr(0, pins[j] / 32, 32'h1 << (pins[j] % 32));
      chk("R12 irq drops after clear", {29'h0, irq_line}, 32'h0);
      wr(1, pins[j] / 32, 32'h0);
      set_pin(pins[j], 1'b0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(1, 1, 32'hFFFF_FFFF);
    rd(1, 1, d);
    chk("R13 bank 1 upper bits read zero", d, 32'h003F_FFFF);
    wr(6, 0, 32'hA5A5_5A5A);
    rd(6, 0, d);
    chk("R13 enable readback", d, 32'hA5A5_5A5A);
    rd(0, 0, d);
    chk("R13 no status from readback", d, 32'h0);
    wr(1, 1, 32'h0);
    wr(6, 0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    pin_raw   = '0;
    pin_sync  = '0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_high();
    t_low();
    t_async();
    t_w1c();
    t_sticky();
    t_collide();
    t_groups();
    t_readback();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule